// File: doc/BRIEF.md
# Programming-Mode Memory Port Controller

This block is the device side of a write-once or light-erasable program memory during programming. It watches the chip-enable, output-enable and program-strobe levels, together with a flag that says the high programming voltage is present. From these it works out whether the host wants to read, verify, latch page data, write a page, write a single byte or do nothing. It releases the data bus in every mode that does not read, and it keeps a small behavioural memory array that can only lose set bits when written.

Programming is possible only while the chip reset input is held low. A page is four bytes, picked by the address bits above the two low ones. The host first fills a page buffer: while the page buffer mode is held, the byte on the data bus goes into the slot chosen by the two low address bits on every clock. The host then pulses the program strobe low to commit the whole page. A single byte can also be written without the buffer. A program pulse counts only if the strobe stays low for a minimum number of clock cycles, and the write happens when the strobe rises again.

Top module: `prog_port_ctrl`

## Requirements
- R1: While `cpu_reset` is high, `dout_en` is 0, the page buffer is not loaded and no program pulse writes the array.
- R2: After `rst_n` is released, every array location reads 8'hFF and every page buffer slot holds 8'hFF.
- R3: With `cpu_reset` low, `ce` low and `oe` low (and `pgm` high when `hv_on` is 1), `dout_en` is 1 and `dout` equals the array byte at `addr` in the same cycle.
- R4: When `oe` is high, or `ce` is high, `dout_en` is 0. When `hv_on` is 1, `pgm` is low and `ce` and `oe` are both low, `dout_en` is also 0.
- R5: With `hv_on` 1, `cpu_reset` low, `ce` 1, `oe` 0 and `pgm` 1, every clock stores `din` into page buffer slot `addr[1:0]`. In no other mode does a slot change.
- R6: A valid pulse with `ce` 1 and `oe` 1 updates the four bytes at addresses {`addr[AW-1:2]`, i}, for i from 0 to 3, using page buffer slot i. The address is the one seen in the last low cycle.
- R7: A valid pulse with `ce` 0 and `oe` 1 updates the byte at `addr` with `din`. Both are taken from the last low cycle of the pulse.
- R8: A pulse is valid only when `pgm` was low with `oe` 1, `hv_on` 1 and `cpu_reset` low for at least MIN_PULSE consecutive clocks. The write happens on the first clock on which `pgm` is seen high again. A shorter pulse writes nothing.
- R9: A write only clears bits: the new byte is the old byte AND the written data.
- R10: While `pgm` stays high, nothing is written, whatever `ce`, `oe`, `addr` and `din` do.
- R11: If `ce` changes during the low phase of a pulse, the pulse writes nothing. The same holds if `oe`, `hv_on` or `cpu_reset` leaves its required level during the low phase.
- R12: With `hv_on` 0 and `ce` high (standby), the bus is released whatever `oe` is, and the page buffer is not loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the buffer, pulse timer and array |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| cpu_reset | input | 1 | Chip reset pin level; programming is possible only while it is low |
| hv_on | input | 1 | 1 while the programming voltage is present |
| ce | input | 1 | Chip-enable pin level |
| oe | input | 1 | Output-enable pin level |
| pgm | input | 1 | Program strobe pin level, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Byte that the host drives onto the bus |
| dout | output | 8 | Byte that the block drives onto the bus; 0 when released |
| dout_en | output | 1 | 1 when the block drives the bus |

## Verification
The bench builds the block with a 64-byte array (AW = 6) and MIN_PULSE = 3. Pulses of two cycles (too short) and three cycles (exactly long enough) therefore take only a few clocks, and several whole pages fit in a short run. The small array also lets the reference model keep its own copy of every byte, so each clock compares the bus against that copy. With these values the bench covers pulses at the length boundary, pulses cut short by a change on `ce`, buffer loading with and without programming voltage, and repeated writes that can only clear bits.

// File: rtl/prog_port_pkg.sv
package prog_port_pkg;

   typedef enum logic [3:0] {
      PM_OFF,
      PM_READ,
      PM_OUT_DIS,
      PM_STANDBY,
      PM_PG_LATCH,
      PM_PG_WRITE,
      PM_BYTE_WRITE,
      PM_VERIFY,
      PM_INHIBIT
   } prog_mode_e;

   function automatic logic mode_drives(prog_mode_e m);
      return (m == PM_READ) || (m == PM_VERIFY);
   endfunction

   function automatic logic mode_pulses(prog_mode_e m);
      return (m == PM_PG_WRITE) || (m == PM_BYTE_WRITE);
   endfunction

endpackage

// File: rtl/prog_mode_dec.sv
module prog_mode_dec
   import prog_port_pkg::*;
(
   input  logic       cpu_reset,
   input  logic       hv_on,
   input  logic       ce,
   input  logic       oe,
   input  logic       pgm,
   output prog_mode_e mode
);

   always_comb begin
      if (cpu_reset) begin
         mode = PM_OFF;
      end else if (!hv_on) begin
         if (ce)      mode = PM_STANDBY;
         else if (oe) mode = PM_OUT_DIS;
         else         mode = PM_READ;
      end else begin
         unique case ({ce, oe, pgm})
            3'b101:         mode = PM_PG_LATCH;
            3'b110:         mode = PM_PG_WRITE;
            3'b010:         mode = PM_BYTE_WRITE;
            3'b001:         mode = PM_VERIFY;
            3'b011, 3'b111: mode = PM_INHIBIT;
            3'b100:         mode = PM_STANDBY;
            default:        mode = PM_OUT_DIS;
         endcase
      end
   end

endmodule

// File: rtl/prog_pulse_timer.sv
module prog_pulse_timer
   import prog_port_pkg::*;
#(
   parameter int AW        = 8,
   parameter int MIN_PULSE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  prog_mode_e    mode,
   input  logic          sess_hv,
   input  logic          pgm,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    din,
   output logic          commit_byte,
   output logic          commit_page,
   output logic [AW-1:0] cap_addr,
   output logic [7:0]    cap_data
);

   localparam int CW = (MIN_PULSE < 1) ? 1 : $clog2(MIN_PULSE + 1);
   localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);

   generate
      if (MIN_PULSE < 1) begin : g_bad_min
         $error("prog_pulse_timer: MIN_PULSE must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          kind_q;
   logic          bad_q;
   logic          low_now;
   logic          kind_now;
   logic          fire;

   assign low_now  = mode_pulses(mode);
   assign kind_now = (mode == PM_PG_WRITE);
   assign fire     = (cnt_q == CMAX) && !bad_q && sess_hv && pgm;

   assign commit_page = fire && kind_q;
   assign commit_byte = fire && !kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         kind_q   <= 1'b0;
         bad_q    <= 1'b0;
         cap_addr <= '0;
         cap_data <= 8'h00;
      end else if (low_now) begin
         cap_addr <= addr;
         cap_data <= din;
         if (cnt_q == '0) begin
            cnt_q  <= CW'(1);
            kind_q <= kind_now;
            bad_q  <= 1'b0;
         end else begin
            if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
            if (kind_now != kind_q) bad_q <= 1'b1;
         end
      end else begin
         cnt_q <= '0;
         bad_q <= 1'b0;
      end
   end

   // R11
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sess_hv |=> (cnt_q == '0));

endmodule

// File: rtl/prog_page_latch.sv
module prog_page_latch #(
   parameter int PG_BITS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [PG_BITS-1:0]           sel,
   input  logic [7:0]                   din,
   output logic [(1<<PG_BITS)-1:0][7:0] slots
);

   localparam int NS = 1 << PG_BITS;

   generate
      for (genvar s = 0; s < NS; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            slots[s] <= 8'hFF;
            else if (load && sel == PG_BITS'(s))   slots[s] <= din;
         end
      end
   endgenerate

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(slots));

endmodule

// File: rtl/prog_array.sv
module prog_array #(
   parameter int AW         = 8,
   parameter int PG_BITS    = 2,
   parameter bit CLEAR_ONLY = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_byte,
   input  logic                         wr_page,
   input  logic [AW-1:0]                waddr,
   input  logic [7:0]                   wdata,
   input  logic [(1<<PG_BITS)-1:0][7:0] slots,
   input  logic [AW-1:0]                raddr,
   output logic [7:0]                   rdata
);

   localparam int DEPTH = 1 << AW;
   localparam int NS    = 1 << PG_BITS;

   logic [7:0] mem [DEPTH];
   logic [7:0] byte_new;
   logic [NS-1:0][7:0] page_new;
   logic [NS-1:0][7:0] page_old;

   always_comb begin
      for (int i = 0; i < NS; i++)
         page_old[i] = mem[{waddr[AW-1:PG_BITS], PG_BITS'(i)}];
   end

   generate
      if (CLEAR_ONLY) begin : g_clear
         assign byte_new = mem[waddr] & wdata;
         assign page_new = page_old & slots;

         // R9
         no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_byte |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == 8'h00));
      end else begin : g_over
         assign byte_new = wdata;
         assign page_new = slots;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= 8'hFF;
      end else if (wr_byte) begin
         mem[waddr] <= byte_new;
      end else if (wr_page) begin
         for (int i = 0; i < NS; i++)
            mem[{waddr[AW-1:PG_BITS], PG_BITS'(i)}] <= page_new[i];
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/prog_port_ctrl.sv
module prog_port_ctrl
   import prog_port_pkg::*;
#(
   parameter int AW         = 8,
   parameter int PG_BITS    = 2,
   parameter int MIN_PULSE  = 4,
   parameter bit CLEAR_ONLY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_reset,
   input  logic          hv_on,
   input  logic          ce,
   input  logic          oe,
   input  logic          pgm,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic          dout_en
);

   localparam int NS = 1 << PG_BITS;

   generate
      if (AW <= PG_BITS) begin : g_bad_aw
         $error("prog_port_ctrl: AW must exceed PG_BITS");
      end
   endgenerate

   prog_mode_e           mode;
   logic                 sess_hv;
   logic                 commit_byte;
   logic                 commit_page;
   logic [AW-1:0]        cap_addr;
   logic [7:0]           cap_data;
   logic [NS-1:0][7:0]   slots;
   logic [7:0]           rdata;

   assign sess_hv = hv_on && !cpu_reset;

   prog_mode_dec u_dec (
      .cpu_reset (cpu_reset),
      .hv_on     (hv_on),
      .ce        (ce),
      .oe        (oe),
      .pgm       (pgm),
      .mode      (mode)
   );

   prog_pulse_timer #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .sess_hv     (sess_hv),
      .pgm         (pgm),
      .addr        (addr),
      .din         (din),
      .commit_byte (commit_byte),
      .commit_page (commit_page),
      .cap_addr    (cap_addr),
      .cap_data    (cap_data)
   );

   prog_page_latch #(.PG_BITS(PG_BITS)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (mode == PM_PG_LATCH),
      .sel   (addr[PG_BITS-1:0]),
      .din   (din),
      .slots (slots)
   );

   prog_array #(.AW(AW), .PG_BITS(PG_BITS), .CLEAR_ONLY(CLEAR_ONLY)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_byte (commit_byte),
      .wr_page (commit_page),
      .waddr   (cap_addr),
      .wdata   (cap_data),
      .slots   (slots),
      .raddr   (addr),
      .rdata   (rdata)
   );

   assign dout_en = mode_drives(mode);
   assign dout    = dout_en ? rdata : 8'h00;

   // R4
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce || oe) |-> !dout_en);

   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reset |-> (!dout_en && !commit_byte && !commit_page));

   // R8
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_byte || commit_page) |-> ($past(!pgm) && pgm));

endmodule

// File: tb/tb_prog_port_ctrl.sv
`timescale 1ns/1ps
module tb_prog_port_ctrl;

   localparam int AW   = 6;
   localparam int PGB  = 2;
   localparam int MINP = 3;
   localparam int DEP  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_reset = 1'b1;
   logic          hv_on = 1'b0;
   logic          ce = 1'b1;
   logic          oe = 1'b1;
   logic          pgm = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = 8'h00;
   logic [7:0]    dout;
   logic          dout_en;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   prog_port_ctrl #(.AW(AW), .PG_BITS(PGB), .MIN_PULSE(MINP), .CLEAR_ONLY(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset), .hv_on(hv_on),
      .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   // behavioural reference
   int m_mem [DEP];
   int m_lat [4];
   int m_cnt;
   int m_kind;
   int m_bad;
   int m_a;
   int m_d;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[k]) m_mem[k] = 255;
         foreach (m_lat[k]) m_lat[k] = 255;
         m_cnt = 0; m_kind = 0; m_bad = 0; m_a = 0; m_d = 0;
      end else begin
         if (!cpu_reset && hv_on && !pgm && oe) begin
            if (m_cnt == 0) begin
               m_cnt = 1; m_kind = ce; m_bad = 0;
            end else begin
               m_cnt = m_cnt + 1;
               if (ce != m_kind) m_bad = 1;
            end
            m_a = addr; m_d = din;
         end else begin
            if (!cpu_reset && hv_on && pgm && m_cnt >= MINP && m_bad == 0) begin
               if (m_kind == 1) begin
                  for (int j = 0; j < 4; j++)
                     m_mem[(m_a / 4) * 4 + j] = m_mem[(m_a / 4) * 4 + j] & m_lat[j];
               end else begin
                  m_mem[m_a] = m_mem[m_a] & m_d;
               end
            end
            m_cnt = 0; m_bad = 0;
         end
         if (!cpu_reset && hv_on && ce && !oe && pgm)
            m_lat[addr % 4] = din;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         automatic int e_en = (!cpu_reset && !ce && !oe && (pgm || !hv_on)) ? 1 : 0;
         chk("R4", dout_en, e_en);
         if (e_en == 1) chk("R3", dout, m_mem[addr]);
      end
   end

   task automatic step(input logic r, input logic h, input logic c, input logic o,
                       input logic p, input int a, input int d);
      @(posedge clk);
      #2;
      cpu_reset = r; hv_on = h; ce = c; oe = o; pgm = p;
      addr = AW'(a); din = d[7:0];
   endtask

   task automatic rd(input int a, input int exp, input string req);
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, a, 0);
      @(negedge clk);
      chk(req, dout, exp);
   endtask

   task automatic pulse(input logic c, input int a, input int d, input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, c, 1'b1, 1'b0, a, d);
      step(1'b0, 1'b1, c, 1'b1, 1'b1, a, d);
   endtask

   initial begin
      #(20 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 / R2: out of programming mode, bus released
      @(negedge clk);
      chk("R1", dout_en, 0);
      rd(0, 8'hFF, "R2");
      rd(DEP - 1, 8'hFF, "R2");

      // R7: byte write, exact minimum pulse
      pulse(1'b0, 3, 8'h5A, MINP);
      rd(3, 8'h5A, "R7");
      // R9: second write can only clear bits
      pulse(1'b0, 3, 8'h0F, MINP);
      rd(3, 8'h0A, "R9");
      // R8: two-cycle pulse ignored
      pulse(1'b0, 5, 8'h00, MINP - 1);
      rd(5, 8'hFF, "R8");
      // R8: longer pulse accepted
      pulse(1'b0, 4, 8'h33, MINP + 4);
      rd(4, 8'h33, "R8");

      // R10: strobe held high, no write
      for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6, 0);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6, 0);
      rd(6, 8'hFF, "R10");

      // R11: ce changes during the low phase
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7, 0);
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7, 0);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7, 0);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7, 0);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7, 0);
      rd(7, 8'hFF, "R11");
      // R11: programming voltage drops during the low phase
      for (int i = 0; i < MINP; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2, 0);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2, 0);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2, 0);
      rd(2, 8'hFF, "R11");

      // R5 / R6: page buffer then page write at page 2 (addresses 8..11)
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8,  8'hA0);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9,  8'hB1);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10, 8'hC2);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11, 8'hD3);
      pulse(1'b1, 9, 8'h00, MINP);
      rd(8,  8'hA0, "R6");
      rd(9,  8'hB1, "R6");
      rd(10, 8'hC2, "R6");
      rd(11, 8'hD3, "R6");
      rd(12, 8'hFF, "R6");

      // R12: no voltage, ce high: standby, buffer untouched
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16, 8'h00);
      @(negedge clk);
      chk("R12", dout_en, 0);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 17, 8'h00);
      @(negedge clk);
      chk("R12", dout_en, 0);
      // R1: chip reset high blocks buffer and pulses
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 18, 8'h00);
      for (int i = 0; i < MINP + 1; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 20, 0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 20, 0);
      @(negedge clk);
      chk("R1", dout_en, 0);
      rd(20, 8'hFF, "R1");
      // R5: page write at page 4 uses unchanged buffer
      pulse(1'b1, 17, 8'h00, MINP);
      rd(16, 8'hA0, "R5");
      rd(19, 8'hD3, "R5");

      // R3: read mode without programming voltage, pgm low
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, 0);
      @(negedge clk);
      chk("R3", dout_en, 1);
      chk("R3", dout, 8'h0A);
      // R4: voltage present, strobe low, ce and oe low: released
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3, 0);
      @(negedge clk);
      chk("R4", dout_en, 0);

      // patterned byte writes across the array, model-compared
      for (int a = 24; a < 32; a++) pulse(1'b0, a, (a * 37) & 255, MINP);
      for (int a = 24; a < 32; a++) rd(a, (a * 37) & 255, "R7");

      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule